// File: doc/BRIEF.md
# Pipelined Burst SRAM Front-End

This block is the synchronous control and data path that sits in front of a 4K x 32 word store. On each rising clock edge it samples an address, two start strobes (a processor-side and a controller-side one), an active-low advance, three chip enables, a global write, a lane-write enable and four per-lane write strobes. From these it opens, continues, suspends, restarts and closes bursts of up to four words. Inside a burst the bottom two address bits step linearly and wrap within the aligned group of four. The upper bits keep the value captured at the start.

Writes are masked per 8-bit lane. Reads leave through two register stages, so a read accepted on one edge shows its word on the output after the second edge that follows. With one word per clock after that, a burst gives a 3-1-1-1 access pattern. A split data-in bus and a data-out bus with a valid flag replace a bidirectional bus. The output enable acts without a clock edge.

Top module: `sram_burst_front`

## Requirements
- R1: After synchronous reset no burst is open, `dout_vld` is 0, `dout` is 0, and cycles with no start strobe perform no access.
- R2: The address and chip enables are captured only on an edge where a start strobe is low. The processor strobe `adsp_n` is ignored while `ce1_n` is high. The controller strobe `adsc_n` is honoured in that case. `addr` changes without a strobe have no effect.
- R3: A start with the device unselected (`ce1_n` high, `ce2` low or `ce3_n` high) closes the burst. It performs no access, and `dout_vld` returns to 0 once the words already in flight have left.
- R4: A read accepted on edge k drives its word on `dout` with `dout_vld` high from just after edge k+2 until edge k+3. Later burst beats follow one per clock.
- R5: Inside an open burst with no start strobe, `adv_n` low adds 1 to address bits [1:0], wrapping from 3 to 0. Bits [11:2] keep the captured value.
- R6: Inside an open burst with no start strobe, `adv_n` high repeats the access at the same address.
- R7: With `gw_n` low, a write-capable cycle writes all four lanes, whatever `bwe_n` and `bw_n` hold.
- R8: With `gw_n` high and `bwe_n` low, only lanes i whose `bw_n[i]` is low are written. Lane i is `din[8i+7:8i]`. With `bwe_n` high, or with all four strobes high, the cycle is a read.
- R9: A cycle started by the processor strobe is always a read; its write controls are ignored on that edge.
- R10: A controller-strobe start inside an open burst restarts the burst at the new address, taking the read or write controls of that edge.
- R11: `dout_vld` is high only while a pipelined read word is present and `oe_n` is low. It follows `oe_n` without waiting for a clock edge. `dout` is 0 whenever `dout_vld` is low.
- R12: Accesses take effect in issue order: a read issued on the edge after a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Word address, captured on a start |
| adsp_n | input | 1 | Processor start strobe, active low |
| adsc_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| bw_n | input | 4 | Per-lane write strobes, active low, bit i = lane i |
| oe_n | input | 1 | Output enable, active low, unclocked |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, 0 when not valid |
| dout_vld | output | 1 | Read data valid |

## Verification
A wrong burst address register shows up as a wrong word on `dout` exactly two edges after the faulty beat is issued. A dropped write is seen the first time that location is read back. A wrong open/closed burst flag shows as `dout_vld` rising or staying low two edges after a continuation cycle. The bench models the store and the two-stage output delay in its own terms and compares `dout_vld` and `dout` on every clock. So any such fault is reported within three clocks of the access it spoils, tagged with the requirement under test at that moment.

// File: rtl/sram_front_pkg.sv
package sram_front_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;
    localparam int BURST_W = 2;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [LANES-1:0]  lanes;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } access_t;

    // Step the in-burst bits, keep the upper bits.
    function automatic logic [ADDR_W-1:0] next_beat(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        r = a;
        r[BURST_W-1:0] = BURST_W'(a[BURST_W-1:0] + 1'b1);
        return r;
    endfunction

    // Lanes to write from the write controls of one cycle.
    function automatic logic [LANES-1:0] lane_mask(input logic gw_n, input logic bwe_n,
                                                   input logic [LANES-1:0] bw_n);
        if (!gw_n)       return '1;
        else if (!bwe_n) return ~bw_n;
        else             return '0;
    endfunction

endpackage

// File: rtl/sram_front_ctrl.sv
module sram_front_ctrl
    import sram_front_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 adsp_n,
    input  logic                 adsc_n,
    input  logic                 adv_n,
    input  logic                 ce1_n,
    input  logic                 ce2,
    input  logic                 ce3_n,
    input  logic                 gw_n,
    input  logic                 bwe_n,
    input  logic [LANES-1:0]     bw_n,
    input  logic [DATA_W-1:0]    din,
    output logic                 burst_on,
    output access_t              req
);

    logic              on_q;
    access_t           req_q;
    logic              p_go, c_go, go, sel;
    logic              nxt_on;
    logic [ADDR_W-1:0] nxt_addr;
    logic [LANES-1:0]  wr_lanes;
    access_t           nxt_req;

    always_comb begin
        p_go = !adsp_n && !ce1_n;
        c_go = !adsc_n && !p_go;
        go   = p_go || c_go;
        sel  = !ce1_n && ce2 && !ce3_n;

        if (go) begin
            nxt_on   = sel;
            nxt_addr = addr;
        end else begin
            nxt_on   = on_q;
            nxt_addr = (on_q && !adv_n) ? next_beat(req_q.addr) : req_q.addr;
        end

        wr_lanes = p_go ? '0 : lane_mask(gw_n, bwe_n, bw_n);

        nxt_req.addr  = nxt_addr;
        nxt_req.wdata = din;
        if (!nxt_on) begin
            nxt_req.op    = OP_IDLE;
            nxt_req.lanes = '0;
        end else if (|wr_lanes) begin
            nxt_req.op    = OP_WRITE;
            nxt_req.lanes = wr_lanes;
        end else begin
            nxt_req.op    = OP_READ;
            nxt_req.lanes = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b0;
            req_q <= '0;
        end else begin
            on_q  <= nxt_on;
            req_q <= nxt_req;
        end
    end

    assign burst_on = on_q;
    assign req      = req_q;

endmodule

// File: rtl/sram_front_array.sv
module sram_front_array
    import sram_front_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           req,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (req.op == OP_WRITE && req.lanes[g])
                cells[req.addr] <= req.wdata[g*LANE_W +: LANE_W];
            if (req.op == OP_READ)
                rd_data[g*LANE_W +: LANE_W] <= cells[req.addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_vld <= 1'b0;
        else     rd_vld <= (req.op == OP_READ);
    end

endmodule

// File: rtl/sram_front_outreg.sv
module sram_front_outreg
    import sram_front_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_vld,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);

    logic              q_vld;
    logic [DATA_W-1:0] q_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_data <= '0;
        end else begin
            q_vld <= rd_vld;
            if (rd_vld) q_data <= rd_data;
        end
    end

    assign dout_vld = q_vld && !oe_n;
    assign dout     = dout_vld ? q_data : '0;

endmodule

// File: rtl/sram_burst_front.sv
module sram_burst_front
    import sram_front_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       adsp_n,
    input  logic                       adsc_n,
    input  logic                       adv_n,
    input  logic                       ce1_n,
    input  logic                       ce2,
    input  logic                       ce3_n,
    input  logic                       gw_n,
    input  logic                       bwe_n,
    input  logic [LANES-1:0]           bw_n,
    input  logic                       oe_n,
    input  logic [DATA_W-1:0]          din,
    output logic [DATA_W-1:0]          dout,
    output logic                       dout_vld
);

    logic              burst_on;
    access_t           req;
    logic              rd_vld;
    logic [DATA_W-1:0] rd_data;

    sram_front_ctrl u_ctrl (
        .clk(clk), .rst(rst), .addr(addr),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .din(din),
        .burst_on(burst_on), .req(req)
    );

    sram_front_array u_array (
        .clk(clk), .rst(rst), .req(req),
        .rd_vld(rd_vld), .rd_data(rd_data)
    );

    sram_front_outreg u_out (
        .clk(clk), .rst(rst), .rd_vld(rd_vld), .rd_data(rd_data),
        .oe_n(oe_n), .dout(dout), .dout_vld(dout_vld)
    );

endmodule

// File: rtl/sram_burst_front_chk.sv
module sram_burst_front_chk
    import sram_front_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              adv_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              gw_n,
    input logic              dout_vld,
    input logic              burst_on,
    input op_e               req_op,
    input logic [LANES-1:0]  req_lanes,
    input logic [ADDR_W-1:0] req_addr
);

    // R9
    pstart_reads_chk: assert property (@(posedge clk) disable iff (rst)
        (!adsp_n && !ce1_n) |=> (req_op != OP_WRITE));

    // R7
    gw_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!gw_n && !adsc_n && adsp_n && !ce1_n && ce2 && !ce3_n)
        |=> (req_op == OP_WRITE && req_lanes == '1));

    // R3
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (!adsc_n && adsp_n && !ce2) |=> (!burst_on && req_op == OP_IDLE));

    // R6
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_on && adsp_n && adsc_n && adv_n) |=> (req_addr == $past(req_addr)));

    // R5
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_on && adsp_n && adsc_n)
        |=> (req_addr[ADDR_W-1:BURST_W] == $past(req_addr[ADDR_W-1:BURST_W])));

    // R4
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> $past(req_op == OP_READ, 2));

endmodule

bind sram_burst_front sram_burst_front_chk u_chk (
    .clk(clk), .rst(rst), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .dout_vld(dout_vld),
    .burst_on(burst_on), .req_op(req.op), .req_lanes(req.lanes), .req_addr(req.addr)
);

// File: tb/sram_burst_front_test.sv
module sram_burst_front_test;
    import sram_front_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst;
    logic [ADDR_W-1:0] addr;
    logic adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n;
    logic [LANES-1:0]  bw_n;
    logic [DATA_W-1:0] din, dout;
    logic dout_vld;

    sram_burst_front uut (
        .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .din(din),
        .dout(dout), .dout_vld(dout_vld)
    );

    int    compared   = 0;
    int    mismatched = 0;
    string phase      = "R1";
    bit    done       = 0;

    // Behavioural reference: word store, open flag, burst address, 3-deep delay.
    logic [DATA_W-1:0] ref_mem [DEPTH];
    bit                ref_open;
    logic [ADDR_W-1:0] ref_addr;
    bit                dly_v [3];
    logic [DATA_W-1:0] dly_d [3];

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
    end

    always @(posedge clk) begin
        bit pstart, cstart, newv;
        logic [LANES-1:0] wl;
        logic [DATA_W-1:0] newd;
        if (rst) begin
            ref_open = 0;
            ref_addr = '0;
            for (int i = 0; i < 3; i++) begin dly_v[i] = 0; dly_d[i] = '0; end
        end else begin
            pstart = !adsp_n && !ce1_n;
            cstart = !adsc_n && !pstart;
            if (pstart || cstart) begin
                ref_open = !ce1_n && ce2 && !ce3_n;
                ref_addr = addr;
            end else if (ref_open && !adv_n) begin
                ref_addr[1:0] = ref_addr[1:0] + 2'd1;
            end
            if (pstart)      wl = '0;
            else if (!gw_n)  wl = '1;
            else if (!bwe_n) wl = ~bw_n;
            else             wl = '0;
            newv = 0;
            newd = '0;
            if (ref_open) begin
                if (wl != '0) begin
                    for (int i = 0; i < LANES; i++)
                        if (wl[i]) ref_mem[ref_addr][i*8 +: 8] = din[i*8 +: 8];
                end else begin
                    newv = 1;
                    newd = ref_mem[ref_addr];
                end
            end
            dly_v[2] = dly_v[1]; dly_d[2] = dly_d[1];
            dly_v[1] = dly_v[0]; dly_d[1] = dly_d[0];
            dly_v[0] = newv;     dly_d[0] = newd;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        bit ev;
        if (!rst && !done) begin
            ev = dly_v[2] && !oe_n;
            compared++;
            if (dout_vld !== ev) begin
                mismatched++;
                $display("FAIL %s dout_vld actual=%b expected=%b t=%0t", phase, dout_vld, ev, $time);
            end else if (ev && dout !== dly_d[2]) begin
                mismatched++;
                $display("FAIL %s dout actual=%h expected=%h t=%0t", phase, dout, dly_d[2], $time);
            end else if (!ev && dout !== '0) begin
                mismatched++;
                $display("FAIL %s (R11) dout actual=%h expected=0 t=%0t", phase, dout, $time);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = '1; din = '0;
    endtask

    task automatic p_go(input logic [ADDR_W-1:0] a);
        idle(); adsp_n = 0; addr = a; tick();
    endtask

    task automatic c_go(input logic [ADDR_W-1:0] a, input logic g, input logic be,
                        input logic [LANES-1:0] b, input logic [DATA_W-1:0] d);
        idle(); adsc_n = 0; addr = a; gw_n = g; bwe_n = be; bw_n = b; din = d; tick();
    endtask

    task automatic step(input logic av, input logic g, input logic be,
                        input logic [LANES-1:0] b, input logic [DATA_W-1:0] d);
        idle(); adv_n = av; gw_n = g; bwe_n = be; bw_n = b; din = d; tick();
    endtask

    task automatic wait_idle(input int n);
        idle();
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        idle(); addr = '0; oe_n = 0; rst = 1;
        repeat (3) tick();
        #3;
        // R1: reset state at the ports
        compared++;
        if (dout_vld !== 1'b0 || dout !== '0) begin
            mismatched++;
            $display("FAIL R1 reset actual=%b/%h expected=0/0", dout_vld, dout);
        end
        rst = 0;
        phase = "R1";
        step(0, 1, 1, '1, '0); step(0, 1, 1, '1, '0);
        wait_idle(3);

        phase = "R7";
        for (int b = 0; b < 16; b++) begin
            c_go(ADDR_W'(b*4), 0, 1, '1, 32'hA500_0000 + b*4);
            for (int k = 1; k < 4; k++) step(0, 0, 0, 4'b1111, 32'hA500_0000 + b*4 + k);
        end
        c_go(12'd4094, 0, 1, '1, 32'hC0DE_0001);
        for (int k = 0; k < 3; k++) step(0, 0, 1, '1, 32'hC0DE_0010 + k);
        wait_idle(2);

        phase = "R4";
        p_go(12'd8);
        for (int k = 0; k < 3; k++) step(0, 1, 1, '1, '0);
        wait_idle(2);

        phase = "R5";
        p_go(12'd4094);
        for (int k = 0; k < 4; k++) step(0, 1, 1, '1, '0);
        wait_idle(2);

        phase = "R9";
        idle(); adsp_n = 0; addr = 12'd16; gw_n = 0; din = 32'hDEAD_BEEF; tick();
        step(0, 1, 1, '1, '0);
        wait_idle(3);

        phase = "R8";
        c_go(12'd20, 1, 0, 4'b1010, 32'h1122_3344);
        step(1, 1, 0, 4'b1111, 32'hFFFF_FFFF);
        step(1, 1, 1, 4'b0000, 32'hFFFF_FFFF);
        step(0, 1, 0, 4'b0110, 32'h5566_7788);
        p_go(12'd20); step(0, 1, 1, '1, '0);
        wait_idle(3);

        phase = "R6";
        p_go(12'd24);
        step(1, 1, 1, '1, '0); step(1, 1, 1, '1, '0);
        step(0, 1, 1, '1, '0); step(1, 1, 1, '1, '0);
        wait_idle(3);

        phase = "R12";
        c_go(12'd30, 0, 1, '1, 32'h0BAD_F00D);
        step(1, 1, 1, '1, '0);
        c_go(12'd31, 1, 0, 4'b1100, 32'h7777_2222);
        p_go(12'd31);
        wait_idle(3);

        phase = "R10";
        p_go(12'd32); step(0, 1, 1, '1, '0);
        c_go(12'd40, 1, 1, '1, '0);
        for (int k = 0; k < 3; k++) step(0, 1, 1, '1, '0);
        c_go(12'd42, 0, 1, '1, 32'h4242_4242);
        step(0, 1, 1, '1, '0);
        p_go(12'd40); step(0, 1, 1, '1, '0); step(0, 1, 1, '1, '0);
        wait_idle(3);

        phase = "R11";
        p_go(12'd44); step(0, 1, 1, '1, '0); step(0, 1, 1, '1, '0);
        oe_n = 1; tick(); tick();
        oe_n = 0; step(0, 1, 1, '1, '0);
        #1 oe_n = 1;
        #2 oe_n = 0;
        wait_idle(3);

        phase = "R3";
        for (int k = 0; k < 3; k++) begin
            p_go(12'd48); step(0, 1, 1, '1, '0);
            idle(); adsc_n = 0; addr = 12'd50;
            if (k == 0) ce1_n = 1; else if (k == 1) ce2 = 0; else ce3_n = 1;
            tick();
            step(0, 1, 1, '1, '0);
            wait_idle(4);
        end
        p_go(12'd48);
        idle(); adsp_n = 0; ce2 = 0; addr = 12'd52; tick();
        wait_idle(4);

        phase = "R2";
        idle(); adsp_n = 0; ce1_n = 1; addr = 12'd52; tick();
        wait_idle(3);
        p_go(12'd52); step(0, 1, 1, '1, '0);
        idle(); adsp_n = 0; ce1_n = 1; addr = 12'd0; tick();
        idle(); addr = 12'd100; adv_n = 0; tick();
        idle(); adsc_n = 0; adsp_n = 0; ce1_n = 1; addr = 12'd4; tick();
        wait_idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule